// File: doc/BRIEF.md
# Switched-Capacitor Digitizer Control Sequencer

This block is the digital control for a switched-capacitor sampling array of several channels, each ending in a parallel Wilkinson converter. While acquiring, it moves a write pointer around a circular bank of storage cells. A single common stop freezes every channel at the same instant. The sequencer then runs one shared conversion ramp. During the ramp a Gray-coded count goes to every cell, and each cell captures that count on the first clock its comparator reports a crossing. All stored samples are therefore converted in the same window, not one at a time.

When conversion ends, an external reader asks for a rectangular region: a range of channels and a run of sample positions counted from the oldest sample. The sequencer streams the codes out one word per clock, in binary. `busy` covers the whole span from stop to the last word, and a stop that arrives in that span is ignored. The conversion window can be narrowed to a bracket of codes through parameters. A cell whose comparator is already high when the ramp starts reads as the bracket's low code. A cell that never fires reads as full scale.

Top module: `scd_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `wr_ptr` is 0 and `busy`, `ramp_en` and `rd_valid` are 0.
- R2: While acquiring without a stop, `wr_ptr` advances by one on every clock and goes from CELLS-1 (259) back to 0.
- R3: A stop seen while acquiring freezes `wr_ptr` and raises `busy` on the next clock. A stop seen while `busy` is high has no effect on the pointer or the sequence.
- R4: One clock after the stop is taken, `ramp_en` goes high. It stays high for exactly RAMP_HI-RAMP_LO+1 clocks, during which the shared count steps from RAMP_LO to RAMP_HI by one per clock.
- R5: Each cell stores the count present on the first ramp clock on which its comparator bit is 1. Later comparator activity, and any activity outside the ramp, is ignored. The stored value is read back as the binary count, so a bit already high on the first ramp clock yields RAMP_LO.
- R6: A cell whose comparator bit is never 1 on a ramp clock reads back as all ones (4095 for 12 bits).
- R7: A read request taken after the ramp streams one word per clock with `rd_valid` high. The words go channel-major from `rd_ch_lo` to `rd_ch_hi`, and within a channel sample k (0 to `rd_smp_num`-1) comes from cell (oldest + `rd_smp_first` + k) mod CELLS. Here oldest is the cell after the frozen `wr_ptr`, taken mod CELLS.
- R8: A read request made while acquiring, while the ramp runs or while words are streaming is ignored.
- R9: `busy` falls on the same clock as the last streamed word is presented. Acquisition then resumes with the pointer advancing from its frozen value.
- R10: Cell results are cleared at every stop, so no code from an earlier event shows up in a later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop | input | 1 | Common stop for all channels |
| cmp | input | NUM_CH*CELLS | Comparator flag per storage cell, bit index = channel*CELLS + cell |
| rd_req | input | 1 | Read request strobe |
| rd_ch_lo | input | clog2(NUM_CH) | First channel to read |
| rd_ch_hi | input | clog2(NUM_CH) | Last channel to read |
| rd_smp_first | input | clog2(CELLS) | Offset of the first sample from the oldest cell |
| rd_smp_num | input | clog2(CELLS+1) | Number of samples per channel, 1 to CELLS |
| wr_ptr | output | clog2(CELLS) | Current write cell |
| ramp_en | output | 1 | Conversion ramp active |
| rd_data | output | CODE_W | Converted code, binary |
| rd_valid | output | 1 | rd_data holds a word this clock |
| busy | output | 1 | Stop taken, read not finished |

## Verification
The hardest states to reach from the ports are the pointer wrapping exactly at the stop point and a cell whose comparator pulses briefly during the ramp or is high before it starts. The bench waits, using its own pointer model, until the pointer reads 259 and then stops, which makes the oldest cell wrap to 0. It drives each event with a different comparator pattern per cell: a level that stays high, a short pulse that may fall below the bracket, and all-ones outside the ramp. Stray stops and read requests are injected during the stopped, ramp and streaming phases.

// File: rtl/scd_pkg.sv
// Shared definitions for the switched-capacitor digitizer sequencer.
package scd_pkg;

    // Top-level sequence: acquire, stopped (one clock), ramp, read out.
    typedef enum logic [1:0] {
        SQ_ACQ  = 2'd0,
        SQ_STOP = 2'd1,
        SQ_CONV = 2'd2,
        SQ_READ = 2'd3
    } seq_state_t;

endpackage

// File: rtl/scd_write_ptr.sv
// Circular write pointer over the storage cells of one channel.
// Advances once per clock while adv is high and wraps from CELLS-1 to 0.
// Assumes adv is low whenever acquisition is frozen.
module scd_write_ptr #(
    parameter int CELLS = 260
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv,
    output logic [$clog2(CELLS)-1:0]   ptr
);
    localparam int AW = $clog2(CELLS);

    // Pointer update: step and wrap, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            if (ptr == AW'(CELLS - 1)) ptr <= '0;
            else                       ptr <= ptr + AW'(1);
        end
    end

    assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < AW'(CELLS));

    assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv && ptr == AW'(CELLS - 1) |=> ptr == '0);

endmodule

// File: rtl/scd_ramp_count.sv
// Shared conversion count. Loaded with RAMP_LO on start, steps by one per
// clock while en is high until RAMP_HI, and is broadcast in Gray code.
// Assumes start and en are never high together.
module scd_ramp_count #(
    parameter int CODE_W  = 12,
    parameter int RAMP_LO = 0,
    parameter int RAMP_HI = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              en,
    output logic [CODE_W-1:0] gray,
    output logic              at_top
);
    logic [CODE_W-1:0] cnt;

    // Binary count register, bounded by the bracket.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CODE_W'(RAMP_LO);
        end else if (en && !at_top) begin
            cnt <= cnt + CODE_W'(1);
        end
    end

    // Gray form of the count and end-of-window flag.
    always_comb begin
        gray   = cnt ^ (cnt >> 1);
        at_top = (cnt == CODE_W'(RAMP_HI));
    end

    assert_cnt_bracket_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt >= CODE_W'(RAMP_LO)) && (cnt <= CODE_W'(RAMP_HI)));

    assert_gray_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en && $past(en) |-> $countones(gray ^ $past(gray)) == 1);

endmodule

// File: rtl/scd_cell_array.sv
// One capture register per storage cell. A clear empties every cell. While
// en is high, a cell whose comparator is set and which has not yet fired
// takes the broadcast Gray count and marks itself as hit.
module scd_cell_array #(
    parameter int NCELLS = 2340,
    parameter int CODE_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           en,
    input  logic [NCELLS-1:0]              cmp,
    input  logic [CODE_W-1:0]              gray,
    output logic [NCELLS-1:0][CODE_W-1:0]  cell_gray,
    output logic [NCELLS-1:0]              cell_hit
);
    for (genvar i = 0; i < NCELLS; i++) begin : g_cell
        // First-crossing capture for cell i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_hit[i]  <= 1'b0;
                cell_gray[i] <= '0;
            end else if (clear) begin
                cell_hit[i]  <= 1'b0;
            end else if (en && cmp[i] && !cell_hit[i]) begin
                cell_hit[i]  <= 1'b1;
                cell_gray[i] <= gray;
            end
        end
    end

endmodule

// File: rtl/scd_readout.sv
// Random-access streaming of converted codes. Records the oldest cell when
// the stop is taken. On a request while armed, walks channels lo..hi and,
// within each, rd_smp_num samples from (oldest + first) mod CELLS.
// One registered word per clock; done pulses on the clock that loads the
// last word. Assumes request fields are in range when a request is taken.
module scd_readout #(
    parameter int NUM_CH = 9,
    parameter int CELLS  = 260,
    parameter int CODE_W = 12
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  capture,
    input  logic                                  arm,
    input  logic [$clog2(CELLS)-1:0]              ptr,
    input  logic                                  rd_req,
    input  logic [$clog2(NUM_CH)-1:0]             rd_ch_lo,
    input  logic [$clog2(NUM_CH)-1:0]             rd_ch_hi,
    input  logic [$clog2(CELLS)-1:0]              rd_smp_first,
    input  logic [$clog2(CELLS+1)-1:0]            rd_smp_num,
    input  logic [NUM_CH*CELLS-1:0][CODE_W-1:0]   cell_gray,
    input  logic [NUM_CH*CELLS-1:0]               cell_hit,
    output logic [CODE_W-1:0]                     rd_data,
    output logic                                  rd_valid,
    output logic                                  done
);
    localparam int NCELLS = NUM_CH * CELLS;
    localparam int AW     = $clog2(CELLS);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int NUM_W  = $clog2(CELLS + 1);
    localparam int SUM_W  = AW + 2;
    localparam int IDX_W  = $clog2(NCELLS);

    logic [AW-1:0]     oldest;
    logic              streaming;
    logic [CH_W-1:0]   ch, ch_hi_r;
    logic [AW-1:0]     first_r;
    logic [NUM_W-1:0]  num_r, k;
    logic [SUM_W-1:0]  sum;
    logic [AW-1:0]     sidx;
    logic [IDX_W-1:0]  idx;
    logic [CODE_W-1:0] g_sel, b_sel, word;
    logic              last;

    // Cell address of the current word and its binary value.
    always_comb begin
        sum = SUM_W'(oldest) + SUM_W'(first_r) + SUM_W'(k);
        if (sum >= SUM_W'(2 * CELLS))  sidx = AW'(sum - SUM_W'(2 * CELLS));
        else if (sum >= SUM_W'(CELLS)) sidx = AW'(sum - SUM_W'(CELLS));
        else                           sidx = AW'(sum);
        idx   = IDX_W'(ch) * IDX_W'(CELLS) + IDX_W'(sidx);
        g_sel = cell_gray[idx];
        for (int b = 0; b < CODE_W; b++) b_sel[b] = ^(g_sel >> b);
        word  = cell_hit[idx] ? b_sel : '1;
        last  = (ch == ch_hi_r) && (k == num_r - NUM_W'(1));
        done  = streaming && last;
    end

    // Oldest-cell capture, request acceptance and address walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oldest    <= '0;
            streaming <= 1'b0;
            ch        <= '0;
            ch_hi_r   <= '0;
            first_r   <= '0;
            num_r     <= '0;
            k         <= '0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (capture) begin
                oldest <= (ptr == AW'(CELLS - 1)) ? '0 : ptr + AW'(1);
            end
            if (streaming) begin
                rd_valid <= 1'b1;
                rd_data  <= word;
                if (last) begin
                    streaming <= 1'b0;
                end else if (k == num_r - NUM_W'(1)) begin
                    k  <= '0;
                    ch <= ch + CH_W'(1);
                end else begin
                    k <= k + NUM_W'(1);
                end
            end else if (arm && rd_req) begin
                streaming <= 1'b1;
                ch        <= rd_ch_lo;
                ch_hi_r   <= rd_ch_hi;
                first_r   <= rd_smp_first;
                num_r     <= rd_smp_num;
                k         <= '0;
            end
        end
    end

    assert_req_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arm && rd_req && !streaming |->
            (rd_ch_lo <= rd_ch_hi) && (rd_ch_hi < CH_W'(NUM_CH)) &&
            (rd_smp_num != '0) && (rd_smp_num <= NUM_W'(CELLS)) &&
            (rd_smp_first < AW'(CELLS)));

    assert_stream_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        streaming |-> arm);

endmodule

// File: rtl/scd_sequencer.sv
// Top of the digitizer control sequencer. Owns the sequence state:
// acquire -> stopped (one clock, clears cells, loads count) -> ramp ->
// read out -> acquire. A stop is only taken while acquiring.
module scd_sequencer
    import scd_pkg::*;
#(
    parameter int NUM_CH  = 9,
    parameter int CELLS   = 260,
    parameter int CODE_W  = 12,
    parameter int RAMP_LO = 0,
    parameter int RAMP_HI = (1 << CODE_W) - 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              stop,
    input  logic [NUM_CH*CELLS-1:0]           cmp,
    input  logic                              rd_req,
    input  logic [$clog2(NUM_CH)-1:0]         rd_ch_lo,
    input  logic [$clog2(NUM_CH)-1:0]         rd_ch_hi,
    input  logic [$clog2(CELLS)-1:0]          rd_smp_first,
    input  logic [$clog2(CELLS+1)-1:0]        rd_smp_num,
    output logic [$clog2(CELLS)-1:0]          wr_ptr,
    output logic                              ramp_en,
    output logic [CODE_W-1:0]                 rd_data,
    output logic                              rd_valid,
    output logic                              busy
);
    localparam int NCELLS = NUM_CH * CELLS;

    seq_state_t                        state;
    logic                              take_stop, adv, at_top, rd_done;
    logic [CODE_W-1:0]                 gray;
    logic [NCELLS-1:0][CODE_W-1:0]     cell_gray;
    logic [NCELLS-1:0]                 cell_hit;

    // Decode of the sequence state into unit controls.
    always_comb begin
        take_stop = (state == SQ_ACQ) && stop;
        adv       = (state == SQ_ACQ) && !stop;
        ramp_en   = (state == SQ_CONV);
        busy      = (state != SQ_ACQ);
    end

    // Sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_ACQ;
        end else begin
            unique case (state)
                SQ_ACQ:  if (stop)    state <= SQ_STOP;
                SQ_STOP:              state <= SQ_CONV;
                SQ_CONV: if (at_top)  state <= SQ_READ;
                SQ_READ: if (rd_done) state <= SQ_ACQ;
                default:              state <= SQ_ACQ;
            endcase
        end
    end

    scd_write_ptr #(.CELLS(CELLS)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .ptr   (wr_ptr)
    );

    scd_ramp_count #(.CODE_W(CODE_W), .RAMP_LO(RAMP_LO), .RAMP_HI(RAMP_HI)) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (state == SQ_STOP),
        .en     (ramp_en),
        .gray   (gray),
        .at_top (at_top)
    );

    scd_cell_array #(.NCELLS(NCELLS), .CODE_W(CODE_W)) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state == SQ_STOP),
        .en        (ramp_en),
        .cmp       (cmp),
        .gray      (gray),
        .cell_gray (cell_gray),
        .cell_hit  (cell_hit)
    );

    scd_readout #(.NUM_CH(NUM_CH), .CELLS(CELLS), .CODE_W(CODE_W)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (take_stop),
        .arm          (state == SQ_READ),
        .ptr          (wr_ptr),
        .rd_req       (rd_req),
        .rd_ch_lo     (rd_ch_lo),
        .rd_ch_hi     (rd_ch_hi),
        .rd_smp_first (rd_smp_first),
        .rd_smp_num   (rd_smp_num),
        .cell_gray    (cell_gray),
        .cell_hit     (cell_hit),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .done         (rd_done)
    );

    assert_stop_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && stop |=> state != SQ_STOP);

    assert_ptr_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wr_ptr) || !$past(busy));

    assert_valid_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(state == SQ_READ));

    assert_ramp_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ramp_en) |-> state == SQ_READ);

endmodule

// File: tb/scd_sequencer_tb.sv
// Self-checking bench: a behavioural model (arrays, a queue of expected
// words) is stepped once per clock and compared with the outputs at the
// falling edge. Inputs change only at the falling edge.
module scd_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 9;
    localparam int CELLS  = 260;
    localparam int CODE_W = 12;
    localparam int LO     = 100;
    localparam int HI     = 400;
    localparam int NCELLS = NUM_CH * CELLS;
    localparam int FULL   = (1 << CODE_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0, stop = 1'b0, rd_req = 1'b0;
    logic [NCELLS-1:0] cmp = '0;
    logic [$clog2(NUM_CH)-1:0] rd_ch_lo = '0, rd_ch_hi = '0;
    logic [$clog2(CELLS)-1:0] rd_smp_first = '0;
    logic [$clog2(CELLS+1)-1:0] rd_smp_num = '0;
    logic [$clog2(CELLS)-1:0] wr_ptr;
    logic ramp_en, rd_valid, busy;
    logic [CODE_W-1:0] rd_data;

    int checks = 0, errors = 0;

    // Model state
    int m_state = 0, m_ptr = 0, m_oldest = 0, m_cnt = 0;
    int m_valid = 0, m_data = 0, m_stream = 0;
    bit m_hit[NCELLS];
    int m_code[NCELLS];
    int q[$];
    int cur_ev = 0, cur_mode = 0;

    scd_sequencer #(.NUM_CH(NUM_CH), .CELLS(CELLS), .CODE_W(CODE_W),
                    .RAMP_LO(LO), .RAMP_HI(HI)) u_dut (
        .clk(clk), .rst_n(rst_n), .stop(stop), .cmp(cmp), .rd_req(rd_req),
        .rd_ch_lo(rd_ch_lo), .rd_ch_hi(rd_ch_hi), .rd_smp_first(rd_smp_first),
        .rd_smp_num(rd_smp_num), .wr_ptr(wr_ptr), .ramp_en(ramp_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int thr(int ev, int i);
        return ((i * 53 + ev * 97) % 420) + 40;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_req(input int lo, input int hi, input int first, input int num);
        rd_ch_lo     = lo[$clog2(NUM_CH)-1:0];
        rd_ch_hi     = hi[$clog2(NUM_CH)-1:0];
        rd_smp_first = first[$clog2(CELLS)-1:0];
        rd_smp_num   = num[$clog2(CELLS+1)-1:0];
    endtask

    // One clock: compare, drive comparators, step the model, advance.
    task automatic cycle();
        check(m_state != 0 ? "R3 wr_ptr frozen" : "R2 wr_ptr", int'(wr_ptr), m_ptr);
        check("R4 ramp_en", int'(ramp_en), (m_state == 2) ? 1 : 0);
        check("R9 busy", int'(busy), (m_state != 0) ? 1 : 0);
        check("R7 rd_valid", int'(rd_valid), m_valid);
        if (m_valid != 0)
            check(m_data == FULL ? "R6 rd_data" : (cur_ev > 0 ? "R10 rd_data" : "R5 rd_data"),
                  int'(rd_data), m_data);
        for (int i = 0; i < NCELLS; i++) begin
            int t = thr(cur_ev, i);
            bit v = 1'b0;
            if (m_state == 2) v = (cur_mode == 1) ? (m_cnt >= t && m_cnt <= t + 3) : (m_cnt >= t);
            else              v = (cur_mode == 2);
            cmp[i] = v;
        end
        m_valid = 0;
        case (m_state)
            0: if (stop) begin m_state = 1; m_oldest = (m_ptr + 1) % CELLS; end
               else m_ptr = (m_ptr + 1) % CELLS;
            1: begin
                m_state = 2; m_cnt = LO;
                for (int i = 0; i < NCELLS; i++) m_hit[i] = 1'b0;
            end
            2: begin
                for (int i = 0; i < NCELLS; i++)
                    if (cmp[i] && !m_hit[i]) begin m_hit[i] = 1'b1; m_code[i] = m_cnt; end
                if (m_cnt == HI) m_state = 3; else m_cnt++;
            end
            default: begin
                if (m_stream != 0) begin
                    m_valid = 1; m_data = q.pop_front();
                    if (q.size() == 0) begin m_stream = 0; m_state = 0; end
                end else if (rd_req) begin
                    for (int c = int'(rd_ch_lo); c <= int'(rd_ch_hi); c++)
                        for (int k = 0; k < int'(rd_smp_num); k++) begin
                            int ix = c * CELLS + (m_oldest + int'(rd_smp_first) + k) % CELLS;
                            q.push_back(m_hit[ix] ? m_code[ix] : FULL);
                        end
                    m_stream = 1;
                end
            end
        endcase
        @(negedge clk);
    endtask

    task automatic run_event(input int ev, input int mode, input int acq_len, input bit at_wrap,
                             input int lo, input int hi, input int first, input int num);
        cur_ev = ev; cur_mode = mode;
        repeat (acq_len) cycle();
        // R8: request while acquiring is ignored
        set_req(0, 0, 0, 1); rd_req = 1'b1; cycle(); rd_req = 1'b0;
        check("R8 req in acquire", int'(rd_valid), 0);
        if (at_wrap) while (m_ptr != CELLS - 1) cycle();
        stop = 1'b1; cycle(); cycle(); stop = 1'b0;   // second stop lands in STOPPED
        while (m_state == 2 && m_cnt < LO + 20) cycle();
        stop = 1'b1; cycle(); stop = 1'b0;            // stop during ramp
        rd_req = 1'b1; cycle(); rd_req = 1'b0;        // request during ramp
        check("R8 req in ramp", int'(rd_valid), 0);
        check("R3 busy holds", int'(busy), 1);
        while (m_state != 3) cycle();
        repeat (3) cycle();
        set_req(lo, hi, first, num); rd_req = 1'b1; cycle(); rd_req = 1'b0;
        repeat (5) cycle();
        set_req(0, 0, 0, 1); rd_req = 1'b1; cycle(); rd_req = 1'b0;  // R8 mid-stream
        while (m_state == 3) cycle();
        repeat (4) cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R9 watchdog expired, sequence did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCELLS; i++) begin m_hit[i] = 1'b0; m_code[i] = 0; end
        repeat (3) @(negedge clk);
        check("R1 wr_ptr", int'(wr_ptr), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 ramp_en", int'(ramp_en), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        run_event(0, 0, 300, 1'b0, 0, 8, 0, CELLS);
        run_event(1, 1, 40, 1'b1, 3, 5, 250, 20);
        run_event(2, 2, 10, 1'b0, 8, 8, 0, 1);
        run_event(3, 0, 25, 1'b0, 0, 1, 5, 7);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule